// File: doc/BRIEF.md
# Indexed CRT Controller Register File

This block is the host-facing register file of a character-cell CRT timing controller. The host reaches it through two ports: an index port that selects a register and a data port that reads or writes the selected register. The stored values leave the block as decoded parallel fields: horizontal and vertical timing, sync widths, character height, cursor shape and enable, a 16-bit display start address, a 16-bit cursor address, and a 14-bit light pen address. The raster counters that consume these fields sit outside the block.

A `resize_o` pulse tells the raster logic that a value setting the frame geometry has actually changed, so a rewrite of an unchanged value costs nothing downstream. A light pen strobe captures the current character address once and then holds it until the host re-arms the latch. The `ext_variant_i` input picks the extended variant, in which the vertical sync width is programmable. In the plain variant that width is fixed at 16 lines.

Top module: `crtc_regfile`

## Requirements
- R1: The block answers only when `addr_i[3:1]` is below 4. Within that window `addr_i[0]`=0 selects the index port and `addr_i[0]`=1 selects the data port, so the same register pair appears at four aliases. Any access outside the window changes no state. The 8-bit index register can be read back and resets to 0.
- R2: Data index 0x00 is horizontal total, 0x01 horizontal displayed, 0x02 horizontal sync position, 0x04 vertical total, 0x05 vertical adjust, 0x06 vertical displayed and 0x07 vertical sync position. Each of these keeps all 8 bits and reads back the value last written.
- R3: Some registers keep fewer bits and drop the rest on write. Index 0x09, the character height in scanlines, keeps bits 4:0. Index 0x0A, cursor start, keeps bits 5:0. Index 0x0B, cursor end, keeps bits 4:0. Index 0x10, light pen high, keeps bits 5:0.
- R4: A write to 0x0A clears `cur_en_o` only when bits 6:5 of the written byte are 01. Any other value of those bits sets `cur_en_o`. `cur_first_o` is bits 4:0 of that write. `cur_en_o` is 1 after reset.
- R5: Index 0x03 stores bits 3:0 as the horizontal sync width and bits 7:4 as a vertical width nibble. With `ext_variant_i`=1, a read returns both nibbles and `v_sync_wid_o` equals the stored nibble. With `ext_variant_i`=0, a read returns only bits 3:0 with the upper nibble zero, and `v_sync_wid_o` is 16.
- R6: `resize_o` is high for exactly the one cycle after a data write to 0x00, 0x01, 0x04, 0x05, 0x06 or 0x09 whose masked value differs from the stored value. It stays low for every other write.
- R7: `start_addr_o` takes its high byte from index 0x0C and its low byte from 0x0D. `cur_addr_o` takes its high byte from 0x0E and its low byte from 0x0F. A write to one byte leaves the other byte unchanged.
- R8: A data read of index 0x08, or of any index from 0x12 upward, returns 0xFF. A data write to those indices changes no output.
- R9: `rdata_o` takes the read value on the clock edge where `rd_i` is high inside the window. It then holds until the next such read. A read and a write in the same cycle return the old value.
- R10: While the latch is clear, `pen_strobe_i` copies `pen_addr_i` into `pen_o` and sets `pen_latched_o`. While the latch is set, strobes are ignored. `pen_clear_i` clears the latch and takes priority over a strobe in the same cycle. A capture overrides a host write to 0x10 or 0x11 in the same cycle. Index 0x10 reads `pen_o[13:8]` and index 0x11 reads `pen_o[7:0]`.
- R11: After reset every data register and `pen_o` are 0, `pen_latched_o` is 0, `resize_o` is 0 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_variant_i | input | 1 | 1 selects the extended variant with a programmable vertical sync width |
| addr_i | input | 4 | Host port address |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered read data |
| pen_strobe_i | input | 1 | Light pen trigger |
| pen_clear_i | input | 1 | Re-arms the light pen latch |
| pen_addr_i | input | 14 | Current character address from the raster logic |
| h_total_o | output | 8 | Horizontal total |
| h_disp_o | output | 8 | Horizontal displayed |
| h_sync_pos_o | output | 8 | Horizontal sync position |
| h_sync_wid_o | output | 4 | Horizontal sync width |
| v_total_o | output | 8 | Vertical total |
| v_adjust_o | output | 8 | Vertical adjust |
| v_disp_o | output | 8 | Vertical displayed |
| v_sync_pos_o | output | 8 | Vertical sync position |
| v_sync_wid_o | output | 5 | Vertical sync width in lines |
| max_scan_o | output | 5 | Character height in scanlines |
| cur_first_o | output | 5 | First cursor scanline |
| cur_last_o | output | 5 | Last cursor scanline |
| cur_en_o | output | 1 | Cursor enable |
| start_addr_o | output | 16 | Display start address |
| cur_addr_o | output | 16 | Cursor address |
| pen_o | output | 14 | Light pen address |
| pen_latched_o | output | 1 | Light pen latch flag |
| resize_o | output | 1 | Geometry change pulse |

## Verification
Most register state in this block drives an output directly, so a wrong stored value shows on that output one cycle after the write that caused it. The bench compares every output against its own model on every clock, so such errors are caught at once.

Two kinds of state are only visible indirectly. The first is the index register and the change detector behind `resize_o`. A wrong index, or a wrong old-value comparison, shows either as a misrouted field in the cycle after the next data write or as a wrong `resize_o` in that cycle. The second is the high nibble of index 0x03 while in the plain variant. It shows only once `ext_variant_i` is raised, so the bench stores values with the plain variant selected and then switches to the extended variant to expose them.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t IX_HTOT   = 8'h00;
  localparam byte_t IX_HDISP  = 8'h01;
  localparam byte_t IX_HSPOS  = 8'h02;
  localparam byte_t IX_SWID   = 8'h03;
  localparam byte_t IX_VTOT   = 8'h04;
  localparam byte_t IX_VADJ   = 8'h05;
  localparam byte_t IX_VDISP  = 8'h06;
  localparam byte_t IX_VSPOS  = 8'h07;
  localparam byte_t IX_MAXSC  = 8'h09;
  localparam byte_t IX_CSTART = 8'h0A;
  localparam byte_t IX_CEND   = 8'h0B;
  localparam byte_t IX_SAH    = 8'h0C;
  localparam byte_t IX_SAL    = 8'h0D;
  localparam byte_t IX_CLH    = 8'h0E;
  localparam byte_t IX_CLL    = 8'h0F;
  localparam byte_t IX_PENH   = 8'h10;
  localparam byte_t IX_PENL   = 8'h11;
  localparam byte_t UNIMP_VAL = 8'hFF;

  function automatic logic is_impl(byte_t ix);
    return (ix <= IX_PENL) && (ix != 8'h08);
  endfunction
endpackage

// File: rtl/crtc_index_port.sv
module crtc_index_port #(
  parameter int ADDR_W = 4,
  parameter int PAIRS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        idx_o,
  output logic              hit_o,
  output logic              data_sel_o,
  output logic              data_wr_o
);
  localparam int PAIR_W = ADDR_W - 1;

  logic [7:0] idx_q;

  assign hit_o      = addr_i[ADDR_W-1:1] < PAIR_W'(PAIRS);
  assign data_sel_o = addr_i[0];
  assign data_wr_o  = wr_i && hit_o && addr_i[0];
  assign idx_o      = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           idx_q <= '0;
    else if (wr_i && hit_o && !addr_i[0])  idx_q <= wdata_i;
  end

  AST_INDEX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && !addr_i[0]) |=> $stable(idx_o)); // R1
endmodule

// File: rtl/crtc_byte_pair.sv
module crtc_byte_pair #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hi_we_i,
  input  logic         lo_we_i,
  input  logic [7:0]   wdata_i,
  output logic [W-1:0] val_o
);
  localparam int HI_W = W - 8;

  logic [HI_W-1:0] hi_q;
  logic [7:0]      lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_we_i) hi_q <= wdata_i[HI_W-1:0];
      if (lo_we_i) lo_q <= wdata_i;
    end
  end

  assign val_o = {hi_q, lo_q};

  AST_PAIR_LO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_we_i |=> $stable(val_o[7:0])); // R7
endmodule

// File: rtl/crtc_lightpen.sv
module crtc_lightpen #(
  parameter int PEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             clear_i,
  input  logic [PEN_W-1:0] cap_i,
  input  logic             hi_we_i,
  input  logic             lo_we_i,
  input  logic [PEN_W-9:0] hi_data_i,
  input  logic [7:0]       lo_data_i,
  output logic [PEN_W-1:0] pen_o,
  output logic             latched_o
);
  logic [PEN_W-1:0] pen_q;
  logic             latched_q;
  logic             capture;

  assign capture = strobe_i && !latched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pen_q     <= '0;
      latched_q <= 1'b0;
    end else begin
      latched_q <= clear_i ? 1'b0 : (latched_q || strobe_i);
      if (capture) pen_q <= cap_i;
      else begin
        if (hi_we_i) pen_q[PEN_W-1:8] <= hi_data_i;
        if (lo_we_i) pen_q[7:0]       <= lo_data_i;
      end
    end
  end

  assign pen_o     = pen_q;
  assign latched_o = latched_q;

  AST_PEN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && !hi_we_i && !lo_we_i) |=> $stable(pen_o)); // R10
  AST_PEN_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !clear_i) |=> latched_o); // R10
  AST_PEN_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !latched_o); // R10
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PAIRS     = 4,
  parameter int PEN_W     = 14,
  parameter int MA_W      = 16,
  parameter int VSW_W     = 5,
  parameter int VSW_FIXED = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_variant_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              pen_strobe_i,
  input  logic              pen_clear_i,
  input  logic [PEN_W-1:0]  pen_addr_i,
  output logic [7:0]        h_total_o,
  output logic [7:0]        h_disp_o,
  output logic [7:0]        h_sync_pos_o,
  output logic [3:0]        h_sync_wid_o,
  output logic [7:0]        v_total_o,
  output logic [7:0]        v_adjust_o,
  output logic [7:0]        v_disp_o,
  output logic [7:0]        v_sync_pos_o,
  output logic [VSW_W-1:0]  v_sync_wid_o,
  output logic [4:0]        max_scan_o,
  output logic [4:0]        cur_first_o,
  output logic [4:0]        cur_last_o,
  output logic              cur_en_o,
  output logic [MA_W-1:0]   start_addr_o,
  output logic [MA_W-1:0]   cur_addr_o,
  output logic [PEN_W-1:0]  pen_o,
  output logic              pen_latched_o,
  output logic              resize_o
);
  localparam int NPAIR = 2;

  logic [7:0] idx;
  logic       hit, data_sel, data_wr;
  logic [7:0] h_total_q, h_disp_q, h_spos_q, v_total_q, v_adj_q, v_disp_q, v_spos_q;
  logic [3:0] h_sw_q, v_sw_q;
  logic [4:0] max_scan_q, cur_end_q;
  logic [5:0] cur_start_q;
  logic       cur_en_q, resize_q, geo_change;
  logic [7:0] rd_val, rdata_q;
  logic [MA_W-1:0] pair_val [NPAIR];

  crtc_index_port #(.ADDR_W(ADDR_W), .PAIRS(PAIRS)) u_index (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i,
    .idx_o(idx), .hit_o(hit), .data_sel_o(data_sel), .data_wr_o(data_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_total_q <= '0; h_disp_q <= '0; h_spos_q <= '0;
      v_total_q <= '0; v_adj_q  <= '0; v_disp_q <= '0; v_spos_q <= '0;
      h_sw_q <= '0; v_sw_q <= '0; max_scan_q <= '0;
      cur_start_q <= '0; cur_end_q <= '0; cur_en_q <= 1'b1;
    end else if (data_wr) begin
      case (idx)
        IX_HTOT:   h_total_q <= wdata_i;
        IX_HDISP:  h_disp_q  <= wdata_i;
        IX_HSPOS:  h_spos_q  <= wdata_i;
        IX_SWID: begin
          h_sw_q <= wdata_i[3:0];
          v_sw_q <= wdata_i[7:4];
        end
        IX_VTOT:   v_total_q  <= wdata_i;
        IX_VADJ:   v_adj_q    <= wdata_i;
        IX_VDISP:  v_disp_q   <= wdata_i;
        IX_VSPOS:  v_spos_q   <= wdata_i;
        IX_MAXSC:  max_scan_q <= wdata_i[4:0];
        IX_CSTART: begin
          cur_start_q <= wdata_i[5:0];
          cur_en_q    <= wdata_i[6:5] != 2'b01; // only 01 blanks the cursor
        end
        IX_CEND:   cur_end_q  <= wdata_i[4:0];
        default: ;
      endcase
    end
  end

  // geometry change: compare against stored value after masking
  always_comb begin
    case (idx)
      IX_HTOT:  geo_change = wdata_i != h_total_q;
      IX_HDISP: geo_change = wdata_i != h_disp_q;
      IX_VTOT:  geo_change = wdata_i != v_total_q;
      IX_VADJ:  geo_change = wdata_i != v_adj_q;
      IX_VDISP: geo_change = wdata_i != v_disp_q;
      IX_MAXSC: geo_change = wdata_i[4:0] != max_scan_q;
      default:  geo_change = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) resize_q <= 1'b0;
    else         resize_q <= data_wr && geo_change;
  end

  genvar g;
  generate
    for (g = 0; g < NPAIR; g++) begin : g_pair
      localparam byte_t HI_IX = IX_SAH + byte_t'(2 * g);
      crtc_byte_pair #(.W(MA_W)) u_pair (
        .clk_i, .rst_ni,
        .hi_we_i(data_wr && idx == HI_IX),
        .lo_we_i(data_wr && idx == HI_IX + 8'd1),
        .wdata_i,
        .val_o(pair_val[g])
      );
    end
  endgenerate

  crtc_lightpen #(.PEN_W(PEN_W)) u_pen (
    .clk_i, .rst_ni,
    .strobe_i(pen_strobe_i), .clear_i(pen_clear_i), .cap_i(pen_addr_i),
    .hi_we_i(data_wr && idx == IX_PENH), .lo_we_i(data_wr && idx == IX_PENL),
    .hi_data_i(wdata_i[PEN_W-9:0]), .lo_data_i(wdata_i),
    .pen_o, .latched_o(pen_latched_o)
  );

  always_comb begin
    case (idx)
      IX_HTOT:   rd_val = h_total_q;
      IX_HDISP:  rd_val = h_disp_q;
      IX_HSPOS:  rd_val = h_spos_q;
      IX_SWID:   rd_val = ext_variant_i ? {v_sw_q, h_sw_q} : {4'h0, h_sw_q};
      IX_VTOT:   rd_val = v_total_q;
      IX_VADJ:   rd_val = v_adj_q;
      IX_VDISP:  rd_val = v_disp_q;
      IX_VSPOS:  rd_val = v_spos_q;
      IX_MAXSC:  rd_val = {3'b0, max_scan_q};
      IX_CSTART: rd_val = {2'b0, cur_start_q};
      IX_CEND:   rd_val = {3'b0, cur_end_q};
      IX_SAH:    rd_val = pair_val[0][MA_W-1:8];
      IX_SAL:    rd_val = pair_val[0][7:0];
      IX_CLH:    rd_val = pair_val[1][MA_W-1:8];
      IX_CLL:    rd_val = pair_val[1][7:0];
      IX_PENH:   rd_val = 8'(pen_o[PEN_W-1:8]);
      IX_PENL:   rd_val = pen_o[7:0];
      default:   rd_val = UNIMP_VAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rdata_q <= '0;
    else if (rd_i && hit) rdata_q <= data_sel ? rd_val : idx;
  end

  assign rdata_o      = rdata_q;
  assign resize_o     = resize_q;
  assign h_total_o    = h_total_q;
  assign h_disp_o     = h_disp_q;
  assign h_sync_pos_o = h_spos_q;
  assign h_sync_wid_o = h_sw_q;
  assign v_total_o    = v_total_q;
  assign v_adjust_o   = v_adj_q;
  assign v_disp_o     = v_disp_q;
  assign v_sync_pos_o = v_spos_q;
  assign v_sync_wid_o = ext_variant_i ? VSW_W'(v_sw_q) : VSW_W'(VSW_FIXED);
  assign max_scan_o   = max_scan_q;
  assign cur_first_o  = cur_start_q[4:0];
  assign cur_last_o   = cur_end_q;
  assign cur_en_o     = cur_en_q;
  assign start_addr_o = pair_val[0];
  assign cur_addr_o   = pair_val[1];

  AST_RESIZE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resize_o |-> $past(wr_i && addr_i[0])); // R6
  AST_UNIMP_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit && data_sel && !is_impl(idx)) |=> rdata_o == UNIMP_VAL); // R8
  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R9
  AST_CUR_EN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i[0]) |=> $stable(cur_en_o)); // R4
endmodule

// File: tb/crtc_regfile_bench.sv
`timescale 1ns/1ps
module crtc_regfile_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ext_variant_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic pen_strobe_i = 1'b0, pen_clear_i = 1'b0;
  logic [13:0] pen_addr_i = '0;
  logic [7:0] rdata_o, h_total_o, h_disp_o, h_sync_pos_o, v_total_o, v_adjust_o, v_disp_o, v_sync_pos_o;
  logic [3:0] h_sync_wid_o;
  logic [4:0] v_sync_wid_o, max_scan_o, cur_first_o, cur_last_o;
  logic cur_en_o, pen_latched_o, resize_o;
  logic [15:0] start_addr_o, cur_addr_o;
  logic [13:0] pen_o;

  always #2.5 clk = ~clk;

  crtc_regfile u_crtc_regfile (
    .clk_i(clk), .rst_ni, .ext_variant_i, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .pen_strobe_i, .pen_clear_i, .pen_addr_i,
    .h_total_o, .h_disp_o, .h_sync_pos_o, .h_sync_wid_o, .v_total_o, .v_adjust_o,
    .v_disp_o, .v_sync_pos_o, .v_sync_wid_o, .max_scan_o, .cur_first_o, .cur_last_o,
    .cur_en_o, .start_addr_o, .cur_addr_o, .pen_o, .pen_latched_o, .resize_o
  );

  int total = 0, bad = 0, cycles = 0;
  bit cmp_en = 0;
  int last_resize;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_reg [0:17];
  int m_idx, m_rdata, m_cur_en, m_latched, m_resize;

  function automatic int mask_of(int ix);
    case (ix)
      9, 11:   return 'h1F;
      10, 16:  return 'h3F;
      default: return 'hFF;
    endcase
  endfunction

  function automatic bit impl(int ix);
    return ix <= 17 && ix != 8;
  endfunction

  function automatic int m_read(int ix);
    if (!impl(ix)) return 'hFF;
    if (ix == 3) return ext_variant_i ? m_reg[3] : (m_reg[3] & 'hF);
    return m_reg[ix];
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_idx = 0; m_rdata = 0; m_cur_en = 1; m_latched = 0; m_resize = 0;
    end else begin
      int a, d, nv, was;
      bit hit;
      a = int'(addr_i); d = int'(wdata_i);
      hit = (a >> 1) < 4;
      m_resize = 0;
      if (rd_i && hit) m_rdata = (a & 1) ? m_read(m_idx) : m_idx;
      if (wr_i && hit) begin
        if ((a & 1) == 0) m_idx = d;
        else if (impl(m_idx)) begin
          nv = d & mask_of(m_idx);
          if ((m_idx inside {0, 1, 4, 5, 6, 9}) && nv != m_reg[m_idx]) m_resize = 1;
          m_reg[m_idx] = nv;
          if (m_idx == 10) m_cur_en = ((d >> 5) & 3) != 1;
        end
      end
      was = m_latched;
      if (pen_strobe_i && !was) begin
        m_reg[16] = (int'(pen_addr_i) >> 8) & 'h3F;
        m_reg[17] = int'(pen_addr_i) & 'hFF;
      end
      m_latched = pen_clear_i ? 0 : (was | int'(pen_strobe_i));
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check("R9 rdata", int'(rdata_o), m_rdata);
      check("R6 resize", int'(resize_o), m_resize);
      check("R2 h_total", int'(h_total_o), m_reg[0]);
      check("R2 h_disp", int'(h_disp_o), m_reg[1]);
      check("R2 h_sync_pos", int'(h_sync_pos_o), m_reg[2]);
      check("R5 h_sync_wid", int'(h_sync_wid_o), m_reg[3] & 'hF);
      check("R5 v_sync_wid", int'(v_sync_wid_o), ext_variant_i ? (m_reg[3] >> 4) : 16);
      check("R2 v_total", int'(v_total_o), m_reg[4]);
      check("R2 v_adjust", int'(v_adjust_o), m_reg[5]);
      check("R2 v_disp", int'(v_disp_o), m_reg[6]);
      check("R2 v_sync_pos", int'(v_sync_pos_o), m_reg[7]);
      check("R3 max_scan", int'(max_scan_o), m_reg[9]);
      check("R4 cur_first", int'(cur_first_o), m_reg[10] & 'h1F);
      check("R4 cur_en", int'(cur_en_o), m_cur_en);
      check("R3 cur_last", int'(cur_last_o), m_reg[11]);
      check("R7 start_addr", int'(start_addr_o), (m_reg[12] << 8) | m_reg[13]);
      check("R7 cur_addr", int'(cur_addr_o), (m_reg[14] << 8) | m_reg[15]);
      check("R10 pen", int'(pen_o), (m_reg[16] << 8) | m_reg[17]);
      check("R10 pen_latched", int'(pen_latched_o), m_latched);
    end
  end

  task automatic bus(int a, bit w, bit r, int d);
    addr_i = 4'(a); wr_i = w; rd_i = r; wdata_i = 8'(d);
    @(negedge clk);
    last_resize = int'(resize_o);
    #1; wr_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic wr_reg(int pair, int ix, int v);
    bus(2 * pair, 1, 0, ix);
    bus(2 * pair + 1, 1, 0, v);
  endtask

  task automatic rd_reg(int pair, int ix, output int v);
    bus(2 * pair, 1, 0, ix);
    bus(2 * pair + 1, 0, 1, 0);
    v = int'(rdata_o);
  endtask

  task automatic pen_op(bit s, bit c, int pa);
    pen_strobe_i = s; pen_clear_i = c; pen_addr_i = 14'(pa);
    @(negedge clk); #1;
    pen_strobe_i = 1'b0; pen_clear_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    cmp_en = 1;
    @(negedge clk); #1;
    // R11 reset state
    check("R11 rdata reset", int'(rdata_o), 0);
    check("R11 start_addr reset", int'(start_addr_o), 0);
    check("R4 cur_en reset", int'(cur_en_o), 1);
    rd_reg(0, 0, v); check("R11 h_total read reset", v, 0);
    bus(0, 0, 1, 0); check("R1 index readback", int'(rdata_o), 0);
    // R1 R2 aliasing and timing bytes
    wr_reg(2, 'h00, 'h71); check("R6 resize on change", last_resize, 1);
    rd_reg(0, 'h00, v); check("R2 h_total alias", v, 'h71);
    wr_reg(3, 'h00, 'h71); check("R6 no resize same value", last_resize, 0);
    wr_reg(1, 'h07, 'h19); rd_reg(3, 'h07, v); check("R2 v_sync_pos", v, 'h19);
    wr_reg(0, 'h02, 'h5A); check("R6 no resize on sync pos", last_resize, 0);
    bus(6, 1, 0, 'h21); bus(6, 0, 1, 0); check("R1 index read alias", int'(rdata_o), 'h21);
    // R1 out-of-window access ignored
    bus(8, 1, 0, 'h00); bus(9, 1, 0, 'hEE); bus(9, 0, 1, 0);
    check("R1 miss keeps rdata", int'(rdata_o), 'h21);
    rd_reg(0, 'h00, v); check("R1 miss write ignored", v, 'h71);
    // R3 masks
    wr_reg(0, 'h09, 'h3F); check("R6 resize max_scan", last_resize, 1);
    rd_reg(0, 'h09, v); check("R3 max_scan mask", v, 'h1F);
    wr_reg(0, 'h09, 'hFF); check("R6 masked equal no resize", last_resize, 0);
    wr_reg(0, 'h0B, 'hFF); rd_reg(0, 'h0B, v); check("R3 cursor end mask", v, 'h1F);
    // R4 cursor enable decode
    wr_reg(0, 'h0A, 'h2E);
    check("R4 disabled by 01", int'(cur_en_o), 0);
    check("R4 first line", int'(cur_first_o), 'h0E);
    rd_reg(0, 'h0A, v); check("R3 cursor start mask", v, 'h2E);
    wr_reg(0, 'h0A, 'h40); check("R4 enabled by 10", int'(cur_en_o), 1);
    rd_reg(0, 'h0A, v); check("R3 cursor start drop bit6", v, 'h00);
    wr_reg(0, 'h0A, 'h20); check("R4 disabled again", int'(cur_en_o), 0);
    wr_reg(0, 'h0A, 'h63); check("R4 enabled by 11", int'(cur_en_o), 1);
    // R5 variant
    wr_reg(0, 'h03, 'hA5);
    rd_reg(0, 'h03, v); check("R5 plain read", v, 'h05);
    check("R5 plain vsw", int'(v_sync_wid_o), 16);
    ext_variant_i = 1'b1;
    rd_reg(0, 'h03, v); check("R5 ext read", v, 'hA5);
    check("R5 ext vsw", int'(v_sync_wid_o), 'hA);
    ext_variant_i = 1'b0;
    // R7 pairs
    wr_reg(0, 'h0C, 'h12); wr_reg(0, 'h0D, 'h34);
    check("R7 start both", int'(start_addr_o), 'h1234);
    wr_reg(0, 'h0D, 'h56); check("R7 start low only", int'(start_addr_o), 'h1256);
    wr_reg(0, 'h0E, 'hBE); wr_reg(0, 'h0F, 'hEF);
    check("R7 cursor addr", int'(cur_addr_o), 'hBEEF);
    rd_reg(0, 'h0E, v); check("R7 cursor high read", v, 'hBE);
    // R8 unimplemented
    wr_reg(0, 'h08, 'h55); rd_reg(0, 'h08, v); check("R8 index 08 read", v, 'hFF);
    wr_reg(0, 'h12, 'h55); rd_reg(0, 'h12, v); check("R8 index 12 read", v, 'hFF);
    rd_reg(0, 'h00, v); check("R8 write ignored", v, 'h71);
    // R9 read and write same cycle returns old
    bus(0, 1, 0, 'h01); bus(1, 1, 1, 'h99); check("R9 old on rd+wr", int'(rdata_o), 0);
    // R10 light pen
    pen_op(1, 0, 'h2ABC);
    check("R10 capture", int'(pen_o), 'h2ABC);
    check("R10 latched", int'(pen_latched_o), 1);
    pen_op(1, 0, 'h1111); check("R10 hold", int'(pen_o), 'h2ABC);
    rd_reg(0, 'h10, v); check("R10 pen high read", v, 'h2A);
    pen_op(1, 1, 'h0333); check("R10 clear wins", int'(pen_latched_o), 0);
    pen_op(1, 0, 'h0777); check("R10 rearmed capture", int'(pen_o), 'h0777);
    pen_op(0, 1, 0);
    wr_reg(0, 'h10, 'hFF); rd_reg(0, 'h10, v); check("R3 pen high mask", v, 'h3F);
    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int a, d;
      a = int'($urandom_range(0, 15));
      d = (a % 2 == 0) ? int'($urandom_range(0, 19)) : int'($urandom_range(0, 255));
      addr_i = 4'(a); wdata_i = 8'(d);
      wr_i = $urandom_range(0, 1) == 1; rd_i = $urandom_range(0, 2) == 0;
      pen_strobe_i = $urandom_range(0, 7) == 0; pen_clear_i = $urandom_range(0, 15) == 0;
      pen_addr_i = 14'($urandom);
      if ($urandom_range(0, 63) == 0) ext_variant_i = ~ext_variant_i;
      @(negedge clk); #1;
    end
    wr_i = 1'b0; rd_i = 1'b0; pen_strobe_i = 1'b0; pen_clear_i = 1'b0;
    @(negedge clk); #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule